// File: doc/BRIEF.md
# Booth Radix-2 Sequential Signed Multiplier

This block multiplies two N-bit two's-complement numbers over N clock cycles and returns the complete 2N-bit signed product. A single accepted `start` captures both operands. The block then runs one recoding step per cycle. When the product is ready it raises `done` for exactly one cycle. The product stays on the output until the next operation is accepted.

Internally there is one 2N-bit shifting register. Its low half is loaded with the multiplier and its high half is cleared. A one-bit "last shifted-out" flop sits beside it and starts at zero. The datapath has one adder, N+1 bits wide, which the step logic uses to add or subtract the captured multiplicand. The step logic treats runs of ones in the multiplier as a subtraction where the run begins and an addition where it ends, so signed operands need no correction pass.

Top module: `booth_mul`

## Requirements
- R1: While reset is low, and at the first clock after it is released, `busy` is 0, `done` is 0 and `product` is 0.
- R2: When `start` is 1 and `busy` is 0 at a rising edge, the operands on `multiplicand` and `multiplier` are captured and `busy` is 1 from the next cycle on.
- R3: `done` is 1 for exactly one cycle. That cycle begins N rising edges after the edge that accepted `start`.
- R4: In the `done` cycle, `product` equals the signed 2N-bit product of the captured operands. This holds for zero, -1, the most negative value times itself and times -1, and arbitrary values.
- R5: A `start` that arrives while `busy` is 1 is ignored. It does not restart the operation, move the `done` cycle, or change the result.
- R6: Changes on `multiplicand` and `multiplier` after the capturing edge do not change the result.
- R7: From the `done` cycle until the next accepted `start`, `product` holds its value.
- R8: Each step looks at the pair (low bit of the shifting register, last shifted-out bit). Pair 10 subtracts the multiplicand from the high half, 01 adds it, and 00 and 11 leave it alone. An arithmetic right shift then follows. The last shifted-out bit is zero at the start of every operation. For N=4, the operands 1010 (-6) and 1011 (-5) give 00011110 (+30).
- R9: `busy` is 1 for exactly N cycles per operation and is never 1 in the same cycle as `done`. A `start` in the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new multiply; taken only while idle |
| multiplicand | input | N | Signed multiplicand |
| multiplier | input | N | Signed multiplier |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: product valid |
| product | output | 2N | Signed full-width product |

## Verification
The bench targets the most negative operand times itself and times -1. In those cases a sum that is not widened to N+1 bits loses its sign on the shift and gives a wrong result. It runs a multiplier of all ones and -6 times -5 (the R8 encoding cases), where a swapped add/subtract choice or a stale last-shifted bit gives the wrong sign or a result that is off by the multiplicand. A start pulse during the operation and operand toggling after capture expose a design that restarts or reads its inputs live: the done pulse would move or the product would change. Idle cycles and back-to-back starts in the done cycle expose a product that drifts while idle and an off-by-one in the iteration count.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;  // capture operands, clear high half and last bit
    logic step;  // one recode + shift iteration
  } boothStrobe_t;
endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output boothStrobe_t strobe,
  output logic         busy,
  output logic         done
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t      state;
  logic [CW-1:0]   iterCnt;
  logic            lastIter;
  logic            doneQ;

  always_comb begin
    strobe.load = (state == ST_IDLE) && start;
    strobe.step = (state == ST_RUN);
    lastIter    = strobe.step && (iterCnt == CW'(N - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= lastIter;
      if (strobe.load) begin
        state   <= ST_RUN;
        iterCnt <= '0;
      end else if (strobe.step) begin
        if (lastIter) state <= ST_IDLE;
        else          iterCnt <= iterCnt + 1'b1;
      end
    end
  end

  assign busy = (state == ST_RUN);
  assign done = doneQ;

  // R3: done is a single-cycle pulse
  a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9: done and busy are exclusive
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));
  // R2: accepted start begins a run at iteration zero
  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && iterCnt == '0));
  // R5: start while running does not reset the iteration count
  a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !lastIter) |=> (busy && iterCnt == $past(iterCnt) + 1'b1));
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub #(
  parameter int W = 33
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         doAdd,
  input  logic         doSub,
  output logic [W-1:0] sum
);
  logic [W-1:0] addend;
  logic         carryIn;

  always_comb begin
    addend  = '0;
    carryIn = 1'b0;
    if (doAdd) begin
      addend = opB;
    end else if (doSub) begin
      addend  = ~opB;
      carryIn = 1'b1;
    end
    sum = opA + addend + {{(W-1){1'b0}}, carryIn};
  end
endmodule

// File: rtl/booth_dp.sv
module booth_dp
  import booth_pkg::*;
#(
  parameter int N = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  boothStrobe_t   strobe,
  input  logic [N-1:0]   multiplicand,
  input  logic [N-1:0]   multiplier,
  output logic [2*N-1:0] product
);
  localparam int PW = 2 * N;
  localparam int AW = N + 1;

  logic [PW-1:0] prodReg;
  logic [N-1:0]  mcandReg;
  logic          lastBit;
  logic [1:0]    recodePair;
  logic [AW-1:0] highExt;
  logic [AW-1:0] mcandExt;
  logic [AW-1:0] stepSum;

  always_comb begin
    recodePair = {prodReg[0], lastBit};
    highExt    = {prodReg[PW-1], prodReg[PW-1:N]};
    mcandExt   = {mcandReg[N-1], mcandReg};
  end

  booth_addsub #(.W(AW)) uAddSub (
    .opA   (highExt),
    .opB   (mcandExt),
    .doAdd (recodePair == 2'b01),
    .doSub (recodePair == 2'b10),
    .sum   (stepSum)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodReg  <= '0;
      mcandReg <= '0;
      lastBit  <= 1'b0;
    end else if (strobe.load) begin
      prodReg  <= {{N{1'b0}}, multiplier};
      mcandReg <= multiplicand;
      lastBit  <= 1'b0;
    end else if (strobe.step) begin
      prodReg  <= {stepSum, prodReg[N-1:1]};
      lastBit  <= prodReg[0];
    end
  end

  assign product = prodReg;

  // R6: captured multiplicand is held during iterations
  a_r6_mcand_held: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load) |=> $stable(mcandReg));
  // R8: last shifted-out bit tracks the bit leaving the register
  a_r8_last_bit: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> (lastBit == $past(prodReg[0])));
endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int N = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [N-1:0]   multiplicand,
  input  logic [N-1:0]   multiplier,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);
  boothStrobe_t strobe;

  booth_ctrl #(.N(N)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  booth_dp #(.N(N)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product)
  );

  // R7: idle without start keeps the product
  a_r7_product_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(product));
endmodule

// File: tb/tb_booth_mul.sv
`timescale 1ns/1ps
module tb_booth_mul;
  localparam int N = 32;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [N-1:0]   multiplicand = '0;
  logic [N-1:0]   multiplier = '0;
  logic           busy;
  logic           done;
  logic [2*N-1:0] product;

  booth_mul #(.N(N)) dut (
    .clk(clk), .rstN(rstN), .start(start),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .busy(busy), .done(done), .product(product)
  );

  always #2 clk = ~clk;

  int    nChecks = 0;
  int    nFails = 0;
  bit    finished = 1'b0;
  string curTag = "R1";

  // Behavioural reference model
  bit                    mBusy = 1'b0;
  bit                    mDone = 1'b0;
  int                    mCnt = 0;
  logic signed [N-1:0]   mA, mB;
  logic signed [2*N-1:0] mProd = '0;

  always @(posedge clk) begin
    logic signed [2*N-1:0] wa, wb;
    if (!rstN) begin
      mBusy = 0; mDone = 0; mCnt = 0; mProd = '0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        mCnt++;
        if (mCnt == N) begin
          mBusy = 0; mDone = 1;
          wa = mA; wb = mB;
          mProd = wa * wb;
        end
      end else if (start) begin
        mBusy = 1; mCnt = 0;
        mA = multiplicand; mB = multiplier;
      end
    end
  end

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      nChecks++;
      if (busy !== mBusy) begin
        nFails++;
        $display("FAIL R9 busy: actual %0b expected %0b (%s)", busy, mBusy, curTag);
      end
      nChecks++;
      if (done !== mDone) begin
        nFails++;
        $display("FAIL R3 done: actual %0b expected %0b (%s)", done, mDone, curTag);
      end
      if (!mBusy) begin
        nChecks++;
        if (product !== mProd) begin
          nFails++;
          $display("FAIL %s product: actual %h expected %h", curTag, product, mProd);
        end
      end
    end
  end

  task automatic runOp(input logic [N-1:0] a, input logic [N-1:0] b);
    @(negedge clk);
    start = 1'b1; multiplicand = a; multiplier = b;
    @(negedge clk);
    start = 1'b0;
    while (!mDone) @(negedge clk);
  endtask

  localparam logic [N-1:0] MINV = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] ONES = '1;

  initial begin
    curTag = "R1";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    curTag = "R4";
    runOp(MINV, MINV);
    runOp(MINV, ONES);
    runOp(ONES, MINV);
    runOp('0, 32'd12345);
    runOp(32'd777, '0);
    runOp(ONES, ONES);
    runOp({1'b0, {(N-1){1'b1}}}, MINV);

    curTag = "R8";
    runOp(-32'sd6, -32'sd5);
    runOp(32'd3, ONES);
    runOp(32'd9, 32'h5555_5555);

    // R5: start pulse while busy
    curTag = "R5";
    @(negedge clk);
    start = 1; multiplicand = 32'd100; multiplier = -32'sd7;
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    start = 1; multiplicand = 32'd1; multiplier = 32'd1;
    @(negedge clk);
    start = 0;
    while (!mDone) @(negedge clk);

    // R6: operands toggle after capture
    curTag = "R6";
    @(negedge clk);
    start = 1; multiplicand = -32'sd31; multiplier = 32'd1001;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < N + 2 && !mDone; i++) begin
      multiplicand = $urandom; multiplier = $urandom;
      @(negedge clk);
    end
    while (!mDone) @(negedge clk);

    // R7: idle cycles with operand noise
    curTag = "R7";
    for (int i = 0; i < 8; i++) begin
      multiplicand = $urandom; multiplier = $urandom;
      @(negedge clk);
    end

    // R9: back-to-back start in the done cycle
    curTag = "R9";
    runOp(32'd5, 32'd6);
    start = 1; multiplicand = -32'sd2; multiplier = 32'd40000;
    @(negedge clk);
    start = 0;
    while (!mDone) @(negedge clk);

    curTag = "R4";
    for (int i = 0; i < 40; i++) runOp($urandom, $urandom);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule